// File: doc/BRIEF.md
# EDO DRAM Device Responder

This block stands in for the memory side of an extended-data-out page-mode DRAM while a DRAM controller is being verified. It samples the row strobe, column strobe, write enable, output enable and the multiplexed address pins on a fast oversampling clock. It stores bytes in an internal array and answers reads on a split data bus made of an input byte, an output byte and a drive-enable. Every strobe edge is resolved to the clock edge at which it is first seen. No analog behaviour or nanosecond delay is modelled.

The row half of the cell index is captured when the row strobe falls. While the column strobe is high, the column half follows the address pins, and it is frozen when the column strobe falls. Read data then stays on the bus after the column strobe rises, which is the defining extended-data-out trait. Writes can start early or late: the data pins stay quiet for an early write, and a late write takes its byte when write enable falls. The array depth is a parameter, so the cell index is the low bits of the full row and column number. Two sticky flags report a row strobe held active too briefly and a precharge that was too short.

Top module: `edo_dram_responder`

## Requirements
- R1: After synchronous reset, dq_oe is 0, both error flags are 0, and every cell reads back as 0x00 until it is written.
- R2: A falling ras_n latches addr as the row; further column cycles under the same low ras_n use that row whatever the address pins carry in between.
- R3: A ras_n-low cycle in which cas_n falls while we_n is high is a read; one clock later dq_out carries the cell whose index is the low log2(DEPTH) bits of row*512 + col, col being addr at the cas_n fall, and dq_oe is 1 while oe_n is 0.
- R4: Read data stays on dq_out with dq_oe high after cas_n rises, until the next cas_n fall or ras_n rise; dq_oe is 0 while oe_n is 1, and it returns when oe_n is 0 again.
- R5: When we_n is low at or before the cas_n fall, the cycle is an early write: dq_in is stored at the cas_n fall and dq_oe stays 0 through the cycle and after cas_n rises.
- R6: When we_n falls while cas_n is already low, dq_in at that we_n fall is stored to the column latched by cas_n, not to the current pins, and dq_oe goes to 0.
- R7: A cas_n fall while ras_n is high neither reads nor writes and does not drive the bus.
- R8: err_active_short is set when ras_n rises after being sampled low on fewer than T_RAS_MIN clock edges (default 4).
- R9: err_precharge_short is set when ras_n falls after being sampled high on fewer than T_RP_MIN clock edges (default 3); the first fall after reset is never flagged.
- R10: Both error flags stay set across later legal cycles and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (9) | Multiplexed row/column address |
| dq_in | input | DATA_W (8) | Byte driven onto the data pins by the controller |
| dq_out | output | DATA_W (8) | Byte driven by the device |
| dq_oe | output | 1 | High while the device drives the data pins |
| err_active_short | output | 1 | Sticky: row strobe active time below minimum |
| err_precharge_short | output | 1 | Sticky: row precharge time below minimum |

## Verification
The hardest case to reach is a late write. Write enable has to fall while the column strobe is already low and a read is already driving the bus, and at that moment the address pins must carry a different column. The stimulus opens a read, waits until the bus shows the old byte, then drops write enable with a new byte and a decoy address. Reading both columns back afterwards shows that the latched column was written and the decoy was not. The timing flags are reached by deliberately shortening one active phase and then one precharge phase. A legal page follows to show that the flags hold, and a reset clears them.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the EDO DRAM responder.
// Assumes: all strobes are active low and sampled on one clock.
package edo_pkg;

    // Edge events seen on the strobe pins at the current clock edge.
    typedef struct packed {
        logic ras_fall;   // ras_n sampled high before, low now
        logic ras_rise;   // ras_n sampled low before, high now
        logic ras_open;   // ras_n low now and at the previous edge
        logic cas_fall;   // cas_n sampled high before, low now
        logic we_fall;    // we_n sampled high before, low now
    } strobe_ev_t;

    // Kind of the column cycle currently in progress.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/edo_pin_sampler.sv
`timescale 1ns/1ps
// Module: edo_pin_sampler
// Keeps the previous sample of each strobe and turns level changes into
// single-cycle edge events.
// Assumes: the strobes stay stable for at least one clock per level,
// and they rest high during reset.
module edo_pin_sampler
    import edo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output strobe_ev_t ev
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pin_now;
    logic [NPIN-1:0] pin_prev;
    logic [NPIN-1:0] pin_fall;
    logic [NPIN-1:0] pin_rise;

    assign pin_now = {we_n, cas_n, ras_n};

    // One history register and one edge pair per strobe.
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        // Remember the level seen at this edge; idle is high.
        always_ff @(posedge clk) begin
            if (!rst_n) pin_prev[g] <= 1'b1;
            else        pin_prev[g] <= pin_now[g];
        end
        assign pin_fall[g] =  pin_prev[g] & ~pin_now[g];
        assign pin_rise[g] = ~pin_prev[g] &  pin_now[g];
    end

    // Pack the events the rest of the block uses.
    always_comb begin
        ev.ras_fall = pin_fall[0];
        ev.ras_rise = pin_rise[0];
        ev.ras_open = ~pin_prev[0] & ~pin_now[0];
        ev.cas_fall = pin_fall[1];
        ev.we_fall  = pin_fall[2];
    end

    logic unused_rise;
    assign unused_rise = |pin_rise[2:1];

endmodule

// File: rtl/edo_timing_guard.sv
`timescale 1ns/1ps
// Module: edo_timing_guard
// Counts the clock edges spent in each row strobe level and raises
// sticky flags when an active phase or a precharge phase is too short.
// Assumes: the minimums are given in oversampling clock edges.
module edo_timing_guard #(
    parameter int T_RAS_MIN = 4,
    parameter int T_RP_MIN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_fall,
    input  logic ras_rise,
    output logic err_active_short,
    output logic err_precharge_short
);
    localparam int CNT_MAX = (T_RAS_MIN > T_RP_MIN) ? T_RAS_MIN : T_RP_MIN;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] level_cnt;

    // Count samples of the current level, saturating; reset counts as long idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          level_cnt <= CW'(CNT_MAX);
        else if (ras_fall || ras_rise)       level_cnt <= CW'(1);
        else if (level_cnt != CW'(CNT_MAX))  level_cnt <= level_cnt + CW'(1);
    end

    // Judge the finished phase at each transition; flags hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_active_short    <= 1'b0;
            err_precharge_short <= 1'b0;
        end else begin
            if (ras_rise && level_cnt < CW'(T_RAS_MIN)) err_active_short    <= 1'b1;
            if (ras_fall && level_cnt < CW'(T_RP_MIN))  err_precharge_short <= 1'b1;
        end
    end

endmodule

// File: rtl/edo_cell_array.sv
`timescale 1ns/1ps
// Module: edo_cell_array
// Byte store with one write port and one combinational read port.
// A per-cell written bit makes unwritten cells read as zero after reset.
// Assumes: DEPTH is a power of two.
module edo_cell_array #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_byte
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  written;

    // Store the byte; the contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_byte;
    end

    // Track which cells hold data since the last reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     written <= '0;
        else if (wr_en) written[wr_idx] <= 1'b1;
    end

    // Return the stored byte or zero for a cell never written.
    assign rd_byte = written[rd_idx] ? cells[rd_idx] : '0;

endmodule

// File: rtl/edo_access_ctrl.sv
`timescale 1ns/1ps
// Module: edo_access_ctrl
// Row and column latches, cycle classification and the data-out stage.
// The column latch follows the pins until the column strobe falls; read
// data is held on the bus until the next column fall or the row closes.
// Assumes: edge events come from edo_pin_sampler on the same clock.
module edo_access_ctrl
    import edo_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_ev_t        ev,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [IDX_W-1:0]  cell_idx,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_byte,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int FULL_W = 2 * ADDR_W;

    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic [ADDR_W-1:0] col_eff;
    logic [DATA_W-1:0] out_q;
    acc_kind_e         kind_q;
    logic              cas_hit;
    logic              late_we;

    // A column cycle only counts with the row already open.
    assign cas_hit = ev.cas_fall & ev.ras_open;
    // Write enable falling inside an already running column cycle.
    assign late_we = ev.we_fall & ~cas_n & ~ev.cas_fall & ev.ras_open;

    // Column latch: transparent up to and including the closing edge.
    assign col_eff = (cas_n || ev.cas_fall) ? addr : col_q;

    // Cell index: low bits of the full row/column number.
    assign cell_idx = IDX_W'({FULL_W'(row_q) << ADDR_W} | FULL_W'(col_eff));

    assign wr_en   = (cas_hit & ~we_n) | late_we;
    assign wr_byte = dq_in;

    // Capture the row on the falling row strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           row_q <= '0;
        else if (ev.ras_fall) row_q <= addr;
    end

    // Freeze the column on the falling column strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       col_q <= '0;
        else if (cas_hit) col_q <= addr;
    end

    // Classify the running column cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           kind_q <= ACC_IDLE;
        else if (ev.ras_rise) kind_q <= ACC_IDLE;
        else if (cas_hit)     kind_q <= we_n ? ACC_READ : ACC_WRITE;
        else if (late_we)     kind_q <= ACC_WRITE;
    end

    // Load the output byte at the start of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)              out_q <= '0;
        else if (cas_hit && we_n) out_q <= rd_byte;
    end

    assign dq_out = out_q;
    assign dq_oe  = (kind_q == ACC_READ) & ~oe_n;

endmodule

// File: rtl/edo_dram_responder.sv
`timescale 1ns/1ps
// Module: edo_dram_responder (top)
// Clocked stand-in for an EDO page-mode DRAM used as a controller target.
// Assumes: the clock is fast enough that every strobe level lasts at
// least one edge, and DEPTH <= 2**(2*ADDR_W) and is a power of two.
module edo_dram_responder
    import edo_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 1024,
    parameter int T_RAS_MIN = 4,
    parameter int T_RP_MIN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              err_active_short,
    output logic              err_precharge_short
);
    localparam int IDX_W = $clog2(DEPTH);

    strobe_ev_t        ev;
    logic [IDX_W-1:0]  cell_idx;
    logic              wr_en;
    logic [DATA_W-1:0] wr_byte;
    logic [DATA_W-1:0] rd_byte;

    edo_pin_sampler u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ev    (ev)
    );

    edo_timing_guard #(
        .T_RAS_MIN (T_RAS_MIN),
        .T_RP_MIN  (T_RP_MIN)
    ) u_guard (
        .clk                 (clk),
        .rst_n               (rst_n),
        .ras_fall            (ev.ras_fall),
        .ras_rise            (ev.ras_rise),
        .err_active_short    (err_active_short),
        .err_precharge_short (err_precharge_short)
    );

    edo_access_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .dq_in    (dq_in),
        .rd_byte  (rd_byte),
        .cell_idx (cell_idx),
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    edo_cell_array #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (cell_idx),
        .wr_byte (wr_byte),
        .rd_idx  (cell_idx),
        .rd_byte (rd_byte)
    );

endmodule

// File: rtl/edo_dram_responder_chk.sv
`timescale 1ns/1ps
// Module: edo_dram_responder_chk
// Port-level protocol properties of the responder, bound to the top.
module edo_dram_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic err_active_short,
    input logic err_precharge_short
);
    // R3: a read column cycle drives the bus on the next edge unless oe_n blocks it.
    p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && we_n && !ras_n && $past(!ras_n)) |=> (dq_oe || oe_n));

    // R4: with the row closed for two samples nothing is driven.
    p_closed_row_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && $past(ras_n)) |-> !dq_oe);

    // R5: an early write keeps the bus released.
    p_early_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n && !ras_n) |=> !dq_oe);

    // R6: a late write releases the bus.
    p_late_write_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) && !cas_n && $past(!cas_n) && !ras_n && $past(!ras_n)) |=> !dq_oe);

    // R10: the flags never drop outside reset.
    p_active_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_active_short |=> err_active_short);

    p_precharge_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_precharge_short |=> err_precharge_short);

endmodule

bind edo_dram_responder edo_dram_responder_chk u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .ras_n               (ras_n),
    .cas_n               (cas_n),
    .we_n                (we_n),
    .oe_n                (oe_n),
    .dq_oe               (dq_oe),
    .err_active_short    (err_active_short),
    .err_precharge_short (err_precharge_short)
);

// File: tb/edo_dram_responder_test.sv
`timescale 1ns/1ps
module edo_dram_responder_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ras_n, cas_n, we_n, oe_n;
    logic [8:0] addr;
    logic [7:0] dq_in;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic       err_active_short, err_precharge_short;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    edo_dram_responder uut (
        .clk                 (clk),
        .rst_n               (rst_n),
        .ras_n               (ras_n),
        .cas_n               (cas_n),
        .we_n                (we_n),
        .oe_n                (oe_n),
        .addr                (addr),
        .dq_in               (dq_in),
        .dq_out              (dq_out),
        .dq_oe               (dq_oe),
        .err_active_short    (err_active_short),
        .err_precharge_short (err_precharge_short)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_row(input logic [8:0] r);
        addr = r; ras_n = 1'b0; tick(1);
    endtask

    task automatic close_row();
        tick(3); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(4);
    endtask

    task automatic read_col(input string tag, input logic [8:0] c, input logic [7:0] exp);
        addr = c; cas_n = 1'b0; tick(1);
        chk({tag, " oe"}, 32'(dq_oe), 32'd1);
        chk({tag, " data"}, 32'(dq_out), 32'(exp));
        cas_n = 1'b1; tick(1);
    endtask

    task automatic early_write(input logic [8:0] c, input logic [7:0] d);
        we_n = 1'b0; dq_in = d; addr = c; tick(1);
        cas_n = 1'b0; tick(1);
        chk("R5 early write quiet at cas fall", 32'(dq_oe), 32'd0);
        cas_n = 1'b1; tick(1);
        chk("R5 early write quiet after cas rise", 32'(dq_oe), 32'd0);
        we_n = 1'b1; tick(1);
    endtask

    // R1 and first-fall part of R9
    task automatic t_reset();
        chk("R1 dq_oe after reset", 32'(dq_oe), 32'd0);
        chk("R1 active flag after reset", 32'(err_active_short), 32'd0);
        chk("R1 precharge flag after reset", 32'(err_precharge_short), 32'd0);
        open_row(9'd3);
        chk("R9 first fall not flagged", 32'(err_precharge_short), 32'd0);
        read_col("R1 unwritten cell 3/7", 9'd7, 8'h00);
        read_col("R1 unwritten cell 3/1ff", 9'h1FF, 8'h00);
        close_row();
    endtask

    // R2, R3, R5
    task automatic t_page_rw();
        open_row(9'd2);
        early_write(9'd5, 8'h5A);
        early_write(9'd6, 8'hA5);
        close_row();
        open_row(9'd2);
        addr = 9'h1F3; tick(1);
        read_col("R2 row kept col 5", 9'd5, 8'h5A);
        addr = 9'h0AA; tick(1);
        read_col("R2 row kept col 6", 9'd6, 8'hA5);
        close_row();
        open_row(9'd3);
        read_col("R3 other row distinct", 9'd5, 8'h00);
        close_row();
        open_row(9'd0);
        read_col("R3 row 0 aliases row 2 at depth 1024", 9'd5, 8'h5A);
        close_row();
    endtask

    // R4
    task automatic t_hold();
        open_row(9'd2);
        read_col("R4 initial read", 9'd5, 8'h5A);
        addr = 9'd9; tick(2);
        chk("R4 held oe after cas rise", 32'(dq_oe), 32'd1);
        chk("R4 held data after cas rise", 32'(dq_out), 32'h5A);
        oe_n = 1'b1; tick(1);
        chk("R4 oe_n high releases", 32'(dq_oe), 32'd0);
        oe_n = 1'b0; tick(1);
        chk("R4 oe_n low drives again", 32'(dq_oe), 32'd1);
        chk("R4 data after oe_n low", 32'(dq_out), 32'h5A);
        read_col("R4 next cas fall replaces", 9'd6, 8'hA5);
        ras_n = 1'b1; tick(1);
        chk("R4 ras rise releases", 32'(dq_oe), 32'd0);
        tick(4);
    endtask

    // R6
    task automatic t_late_write();
        open_row(9'd1);
        addr = 9'd8; cas_n = 1'b0; tick(1);
        chk("R6 read before late write oe", 32'(dq_oe), 32'd1);
        chk("R6 read before late write data", 32'(dq_out), 32'h00);
        dq_in = 8'h3C; addr = 9'h044; we_n = 1'b0; tick(1);
        chk("R6 late write releases bus", 32'(dq_oe), 32'd0);
        cas_n = 1'b1; we_n = 1'b1; tick(1);
        chk("R6 bus stays released", 32'(dq_oe), 32'd0);
        read_col("R6 latched column written", 9'd8, 8'h3C);
        read_col("R6 decoy column untouched", 9'h044, 8'h00);
        close_row();
    endtask

    // R7
    task automatic t_cas_only();
        addr = 9'h010; dq_in = 8'hEE; we_n = 1'b0; cas_n = 1'b0; tick(2);
        chk("R7 no drive with row closed", 32'(dq_oe), 32'd0);
        cas_n = 1'b1; we_n = 1'b1; tick(4);
        open_row(9'd1);
        read_col("R7 no write with row closed", 9'h010, 8'h00);
        close_row();
    endtask

    // R8, R9, R10 and reset clearing of R1
    task automatic t_timing();
        chk("R8 no flag after legal traffic", 32'(err_active_short), 32'd0);
        chk("R9 no flag after legal traffic", 32'(err_precharge_short), 32'd0);
        addr = 9'd0; ras_n = 1'b0; tick(2);
        ras_n = 1'b1; tick(1);
        chk("R8 short active phase flagged", 32'(err_active_short), 32'd1);
        chk("R9 not yet flagged", 32'(err_precharge_short), 32'd0);
        ras_n = 1'b0; tick(1);
        chk("R9 short precharge flagged", 32'(err_precharge_short), 32'd1);
        tick(4); ras_n = 1'b1; tick(4);
        open_row(9'd2);
        read_col("R10 legal page after errors", 9'd5, 8'h5A);
        close_row();
        chk("R10 active flag held", 32'(err_active_short), 32'd1);
        chk("R10 precharge flag held", 32'(err_precharge_short), 32'd1);
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
        chk("R10 active flag cleared by reset", 32'(err_active_short), 32'd0);
        chk("R10 precharge flag cleared by reset", 32'(err_precharge_short), 32'd0);
        open_row(9'd2);
        read_col("R1 cell zero after reset", 9'd5, 8'h00);
        close_row();
    endtask

    initial begin
        rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        addr = '0; dq_in = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_page_rw();
        t_hold();
        t_late_write();
        t_cas_only();
        t_timing();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule